// File: doc/BRIEF.md
# Ring Buffer Pointer Tracker with Run-Time Size

This block keeps the producer and consumer positions of a circular queue that lives in system memory. The queue holds a power-of-two number of entries. Software picks that number at run time by writing a 5-bit log2 value into the low bits of a configuration word. The upper bits of the same word give the byte address of entry zero.

Each pointer is a raw register value. Its low `log2` bits are the slot index. The bit just above the index is a lap flag, which flips every time the index rolls over. From the two pointers the block derives three flags: empty, full, and a flag for pointer pairs that no legal sequence of produce and consume steps can reach.

Hardware engines advance the pointers with one-cycle strobes. Software may also overwrite either pointer directly. For each side the block also reports the current index, the lap flag, and the memory address of the slot the pointer names. Reading and writing the entries themselves is left to the engines around it.

Top module: `qptr_ring_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers become 0. The outputs after that edge show empty=1, full=0, inconsistent=0, index 0 and lap flag 0 on both sides. Both addresses equal the base address.
- R2: The effective size exponent L is `base_i[4:0]`, clamped to MAX_LOG2 when the field is larger. The index is pointer bits [L-1:0] (zero when L is 0). The lap flag is pointer bit L. The base address is `base_i` with bits [4:0] cleared.
- R3: An increment strobe (without a write on the same side) replaces the index with (index+1) mod 2^L. The lap flag toggles exactly when the new index is 0. Pointer bits above L are left unchanged.
- R4: `empty_o` is 1 exactly when the two indices are equal and the two lap flags are equal.
- R5: `full_o` is 1 exactly when the two indices are equal and the two lap flags differ.
- R6: `inconsistent_o` is 1 exactly in two cases. The first is a producer index greater than the consumer index with differing lap flags. The second is a producer index less than the consumer index with equal lap flags. Pointer bits above L never affect any flag.
- R7: Each address output equals the base address plus ENTRY_BYTES times that side's index, modulo 2^ADDR_W.
- R8: A write strobe loads the full pointer value verbatim. It takes priority over an increment strobe on the same side in the same cycle.
- R9: The two sides are independent. Producer and consumer strobes in the same cycle both take effect.
- R10: Every output is registered. It reflects the strobes and `base_i` sampled at the previous clock edge. With no strobe on a side, that pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | ADDR_W | Bits [4:0] hold the log2 entry count; the remaining bits hold the ring's base address |
| prod_inc_i | input | 1 | Advance the producer pointer by one slot |
| cons_inc_i | input | 1 | Advance the consumer pointer by one slot |
| prod_wr_i | input | 1 | Load the producer pointer from `prod_wr_data_i` |
| prod_wr_data_i | input | PTR_W | New producer pointer value |
| cons_wr_i | input | 1 | Load the consumer pointer from `cons_wr_data_i` |
| cons_wr_data_i | input | PTR_W | New consumer pointer value |
| prod_ptr_o | output | PTR_W | Raw producer pointer |
| cons_ptr_o | output | PTR_W | Raw consumer pointer |
| prod_idx_o | output | MAX_LOG2 | Producer slot index |
| prod_wrap_o | output | 1 | Producer lap flag |
| cons_idx_o | output | MAX_LOG2 | Consumer slot index |
| cons_wrap_o | output | 1 | Consumer lap flag |
| prod_addr_o | output | ADDR_W | Byte address of the producer slot |
| cons_addr_o | output | ADDR_W | Byte address of the consumer slot |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds 2^L entries |
| inconsistent_o | output | 1 | Pointer pair is unreachable by legal operation |

## Verification
Two kinds of internal fault show up differently at the ports.

A wrong mask, for example from an off-by-one in the clamp or the shift, moves the lap bit. The error then appears within one cycle as swapped empty/full flags, or as a spurious inconsistent flag, for pairs that differ only in the bits near L.

A faulty increment appears one cycle after the strobe as a wrong raw pointer. The most likely failures are a missed lap toggle at the roll-over slot, or a carry into the bits above L.

The sweeps therefore cover every index/lap pair at each legal size, including clamped sizes, with junk upper bits. They also step each pointer through more than a full double lap, so every roll-over is observed.

// File: rtl/qptr_pkg.sv
package qptr_pkg;
  // Width of the size exponent field at the bottom of the base word
  localparam int LOG2_FIELD_W = 5;

  typedef struct packed {
    logic empty;
    logic full;
    logic incons;
  } qptr_flags_t;
endpackage

// File: rtl/qptr_cfg_decode.sv
module qptr_cfg_decode
  import qptr_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int PTR_W    = 20,
  parameter int MAX_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  output logic [PTR_W-1:0]  idx_mask_o,
  output logic [PTR_W-1:0]  wrap_mask_o,
  output logic [ADDR_W-1:0] base_addr_o
);
  localparam int LW = $clog2(MAX_LOG2 + 1);

  logic [LOG2_FIELD_W-1:0] field;
  logic [LW-1:0]           log2_eff;

  assign field = base_i[LOG2_FIELD_W-1:0];

  // Sizes above the supported maximum are clamped
  always_comb begin
    if (field > LOG2_FIELD_W'(MAX_LOG2)) log2_eff = LW'(MAX_LOG2);
    else                                  log2_eff = LW'(field);
  end

  assign wrap_mask_o = PTR_W'(1) << log2_eff;
  assign idx_mask_o  = wrap_mask_o - PTR_W'(1);
  assign base_addr_o = {base_i[ADDR_W-1:LOG2_FIELD_W], {LOG2_FIELD_W{1'b0}}};
endmodule

// File: rtl/qptr_step.sv
module qptr_step #(
  parameter int PTR_W = 20
) (
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] idx_mask_i,
  input  logic [PTR_W-1:0] wrap_mask_i,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wr_data_i,
  output logic [PTR_W-1:0] ptr_nxt_o
);
  logic [PTR_W-1:0] keep_hi, idx_next, wrap_cur, wrap_next, bumped;
  logic             rolls;

  assign keep_hi   = ptr_i & ~(idx_mask_i | wrap_mask_i);
  assign idx_next  = (ptr_i + PTR_W'(1)) & idx_mask_i;
  assign rolls     = (ptr_i & idx_mask_i) == idx_mask_i;
  assign wrap_cur  = ptr_i & wrap_mask_i;
  assign wrap_next = rolls ? (wrap_cur ^ wrap_mask_i) : wrap_cur;
  assign bumped    = keep_hi | wrap_next | idx_next;

  // Reset first, then software write, then hardware increment
  always_comb begin
    if (rst)        ptr_nxt_o = '0;
    else if (wr_i)  ptr_nxt_o = wr_data_i;
    else if (inc_i) ptr_nxt_o = bumped;
    else            ptr_nxt_o = ptr_i;
  end
endmodule

// File: rtl/qptr_view.sv
module qptr_view #(
  parameter int ADDR_W      = 48,
  parameter int PTR_W       = 20,
  parameter int MAX_LOG2    = 16,
  parameter int ENTRY_BYTES = 32
) (
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic [PTR_W-1:0]    idx_mask_i,
  input  logic [PTR_W-1:0]    wrap_mask_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  output logic [MAX_LOG2-1:0] idx_o,
  output logic                wrap_o,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [PTR_W-1:0] masked;

  assign masked = ptr_i & idx_mask_i;
  assign idx_o  = MAX_LOG2'(masked);
  assign wrap_o = |(ptr_i & wrap_mask_i);
  assign addr_o = base_addr_i + ADDR_W'(idx_o) * ADDR_W'(ENTRY_BYTES);
endmodule

// File: rtl/qptr_compare.sv
module qptr_compare
  import qptr_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic [PTR_W-1:0] prod_i,
  input  logic [PTR_W-1:0] cons_i,
  input  logic [PTR_W-1:0] idx_mask_i,
  input  logic [PTR_W-1:0] wrap_mask_i,
  output qptr_flags_t      flags_o
);
  logic [PTR_W-1:0] p_idx, c_idx;
  logic             p_lap, c_lap, same_idx, same_lap;

  assign p_idx    = prod_i & idx_mask_i;
  assign c_idx    = cons_i & idx_mask_i;
  assign p_lap    = |(prod_i & wrap_mask_i);
  assign c_lap    = |(cons_i & wrap_mask_i);
  assign same_idx = p_idx == c_idx;
  assign same_lap = p_lap == c_lap;

  assign flags_o.empty  = same_idx && same_lap;
  assign flags_o.full   = same_idx && !same_lap;
  assign flags_o.incons = ((p_idx > c_idx) && !same_lap) ||
                          ((p_idx < c_idx) && same_lap);
endmodule

// File: rtl/qptr_ring_unit.sv
module qptr_ring_unit
  import qptr_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int PTR_W       = 20,  // must exceed MAX_LOG2
  parameter int MAX_LOG2    = 16,
  parameter int ENTRY_BYTES = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic                prod_inc_i,
  input  logic                cons_inc_i,
  input  logic                prod_wr_i,
  input  logic [PTR_W-1:0]    prod_wr_data_i,
  input  logic                cons_wr_i,
  input  logic [PTR_W-1:0]    cons_wr_data_i,
  output logic [PTR_W-1:0]    prod_ptr_o,
  output logic [PTR_W-1:0]    cons_ptr_o,
  output logic [MAX_LOG2-1:0] prod_idx_o,
  output logic                prod_wrap_o,
  output logic [MAX_LOG2-1:0] cons_idx_o,
  output logic                cons_wrap_o,
  output logic [ADDR_W-1:0]   prod_addr_o,
  output logic [ADDR_W-1:0]   cons_addr_o,
  output logic                empty_o,
  output logic                full_o,
  output logic                inconsistent_o
);
  localparam int NSIDE = 2;  // side 0 = producer, side 1 = consumer

  logic [PTR_W-1:0]  idx_mask, wrap_mask;
  logic [ADDR_W-1:0] base_addr;

  logic [NSIDE-1:0]    inc_s, wr_s;
  logic [PTR_W-1:0]    wr_data_s [NSIDE];
  logic [PTR_W-1:0]    ptr_q     [NSIDE];
  logic [PTR_W-1:0]    ptr_nxt   [NSIDE];
  logic [MAX_LOG2-1:0] idx_nxt   [NSIDE];
  logic [MAX_LOG2-1:0] idx_q     [NSIDE];
  logic [NSIDE-1:0]    wrap_nxt, wrap_q;
  logic [ADDR_W-1:0]   addr_nxt  [NSIDE];
  logic [ADDR_W-1:0]   addr_q    [NSIDE];

  qptr_flags_t flags_nxt, flags_q;

  assign inc_s        = {cons_inc_i, prod_inc_i};
  assign wr_s         = {cons_wr_i, prod_wr_i};
  assign wr_data_s[0] = prod_wr_data_i;
  assign wr_data_s[1] = cons_wr_data_i;

  qptr_cfg_decode #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LOG2(MAX_LOG2)
  ) u_dec (
    .base_i      (base_i),
    .idx_mask_o  (idx_mask),
    .wrap_mask_o (wrap_mask),
    .base_addr_o (base_addr)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    qptr_step #(.PTR_W(PTR_W)) u_step (
      .rst         (rst),
      .ptr_i       (ptr_q[s]),
      .idx_mask_i  (idx_mask),
      .wrap_mask_i (wrap_mask),
      .inc_i       (inc_s[s]),
      .wr_i        (wr_s[s]),
      .wr_data_i   (wr_data_s[s]),
      .ptr_nxt_o   (ptr_nxt[s])
    );

    // View of the next pointer so every output register agrees after the edge
    qptr_view #(
      .ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LOG2(MAX_LOG2), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_view (
      .ptr_i       (ptr_nxt[s]),
      .idx_mask_i  (idx_mask),
      .wrap_mask_i (wrap_mask),
      .base_addr_i (base_addr),
      .idx_o       (idx_nxt[s]),
      .wrap_o      (wrap_nxt[s]),
      .addr_o      (addr_nxt[s])
    );

    always_ff @(posedge clk) begin
      ptr_q[s]  <= ptr_nxt[s];
      idx_q[s]  <= idx_nxt[s];
      wrap_q[s] <= wrap_nxt[s];
      addr_q[s] <= addr_nxt[s];
    end
  end

  qptr_compare #(.PTR_W(PTR_W)) u_cmp (
    .prod_i      (ptr_nxt[0]),
    .cons_i      (ptr_nxt[1]),
    .idx_mask_i  (idx_mask),
    .wrap_mask_i (wrap_mask),
    .flags_o     (flags_nxt)
  );

  always_ff @(posedge clk) begin
    flags_q <= flags_nxt;
  end

  assign prod_ptr_o     = ptr_q[0];
  assign cons_ptr_o     = ptr_q[1];
  assign prod_idx_o     = idx_q[0];
  assign cons_idx_o     = idx_q[1];
  assign prod_wrap_o    = wrap_q[0];
  assign cons_wrap_o    = wrap_q[1];
  assign prod_addr_o    = addr_q[0];
  assign cons_addr_o    = addr_q[1];
  assign empty_o        = flags_q.empty;
  assign full_o         = flags_q.full;
  assign inconsistent_o = flags_q.incons;
endmodule

// File: rtl/qptr_ring_unit_chk.sv
module qptr_ring_unit_chk #(
  parameter int PTR_W    = 20,
  parameter int MAX_LOG2 = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                prod_inc_i,
  input logic                cons_inc_i,
  input logic                prod_wr_i,
  input logic [PTR_W-1:0]    prod_wr_data_i,
  input logic                cons_wr_i,
  input logic [PTR_W-1:0]    cons_wr_data_i,
  input logic [PTR_W-1:0]    prod_ptr_o,
  input logic [PTR_W-1:0]    cons_ptr_o,
  input logic [MAX_LOG2-1:0] prod_idx_o,
  input logic                prod_wrap_o,
  input logic [MAX_LOG2-1:0] cons_idx_o,
  input logic                cons_wrap_o,
  input logic                empty_o,
  input logic                full_o,
  input logic                inconsistent_o
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty_o && prod_ptr_o == '0 && cons_ptr_o == '0));

  assert_prod_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (prod_inc_i && !prod_wr_i) |=> prod_ptr_o != $past(prod_ptr_o));

  assert_cons_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (cons_inc_i && !cons_wr_i) |=> cons_ptr_o != $past(cons_ptr_o));

  if (PTR_W > MAX_LOG2 + 1) begin : g_hi
    assert_prod_hi_kept_R3: assert property (@(posedge clk) disable iff (rst)
      (prod_inc_i && !prod_wr_i) |=>
        prod_ptr_o[PTR_W-1:MAX_LOG2+1] == $past(prod_ptr_o[PTR_W-1:MAX_LOG2+1]));
  end

  assert_empty_match_R4: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> (prod_idx_o == cons_idx_o && prod_wrap_o == cons_wrap_o));

  assert_full_match_R5: assert property (@(posedge clk) disable iff (rst)
    full_o |-> (prod_idx_o == cons_idx_o && prod_wrap_o != cons_wrap_o));

  assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({empty_o, full_o, inconsistent_o}));

  assert_prod_write_R8: assert property (@(posedge clk) disable iff (rst)
    prod_wr_i |=> prod_ptr_o == $past(prod_wr_data_i));

  assert_cons_write_R8: assert property (@(posedge clk) disable iff (rst)
    cons_wr_i |=> cons_ptr_o == $past(cons_wr_data_i));

  assert_prod_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!prod_inc_i && !prod_wr_i) |=> $stable(prod_ptr_o));

  assert_cons_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!cons_inc_i && !cons_wr_i) |=> $stable(cons_ptr_o));
endmodule

bind qptr_ring_unit qptr_ring_unit_chk #(.PTR_W(PTR_W), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .prod_inc_i     (prod_inc_i),
  .cons_inc_i     (cons_inc_i),
  .prod_wr_i      (prod_wr_i),
  .prod_wr_data_i (prod_wr_data_i),
  .cons_wr_i      (cons_wr_i),
  .cons_wr_data_i (cons_wr_data_i),
  .prod_ptr_o     (prod_ptr_o),
  .cons_ptr_o     (cons_ptr_o),
  .prod_idx_o     (prod_idx_o),
  .prod_wrap_o    (prod_wrap_o),
  .cons_idx_o     (cons_idx_o),
  .cons_wrap_o    (cons_wrap_o),
  .empty_o        (empty_o),
  .full_o         (full_o),
  .inconsistent_o (inconsistent_o)
);

// File: tb/qptr_ring_unit_tb.sv
module qptr_ring_unit_tb_top;
  localparam int ADDR_W = 32;
  localparam int PTR_W  = 8;
  localparam int MAXL   = 4;
  localparam int EBYTES = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] base_i = '0;
  logic              prod_inc_i = 0, cons_inc_i = 0, prod_wr_i = 0, cons_wr_i = 0;
  logic [PTR_W-1:0]  prod_wr_data_i = '0, cons_wr_data_i = '0;
  logic [PTR_W-1:0]  prod_ptr_o, cons_ptr_o;
  logic [MAXL-1:0]   prod_idx_o, cons_idx_o;
  logic              prod_wrap_o, cons_wrap_o, empty_o, full_o, inconsistent_o;
  logic [ADDR_W-1:0] prod_addr_o, cons_addr_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  qptr_ring_unit #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LOG2(MAXL), .ENTRY_BYTES(EBYTES)
  ) dut_i (.*);

  // Bench-side model state
  int unsigned mp = 0, mc = 0;
  logic [ADDR_W-1:0] mbase = '0;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (prod=0x%0h cons=0x%0h base=0x%0h)",
               tag, act, exp, mp, mc, mbase);
    end
  endtask

  function automatic int unsigned eff_l(input logic [ADDR_W-1:0] b);
    int f = int'(b % 32);
    return (f > MAXL) ? MAXL : f;
  endfunction

  function automatic int unsigned bump(input int unsigned p, input int unsigned l);
    int unsigned sz = 1 << l;
    int unsigned ix = p % sz;
    int unsigned w  = (p / sz) % 2;
    int unsigned hi = p / (2 * sz);
    int unsigned ix2 = (ix + 1) % sz;
    int unsigned w2  = (ix + 1 == sz) ? (w ^ 1) : w;
    return (hi * 2 * sz + w2 * sz + ix2) % 256;
  endfunction

  task automatic check_all(input string ptag);
    int unsigned sz = 1 << eff_l(mbase);
    int unsigned pi = mp % sz, ci = mc % sz;
    int unsigned pw = (mp / sz) % 2, cw = (mc / sz) % 2;
    longint unsigned ba = longint'(mbase) & 64'hFFFF_FFE0;
    chk({ptag, " prod_ptr"}, prod_ptr_o, mp);
    chk({ptag, " cons_ptr"}, cons_ptr_o, mc);
    chk("R2 index/lap view", {prod_idx_o, prod_wrap_o, cons_idx_o, cons_wrap_o},
        (pi << 6) | (pw << 5) | (ci << 1) | cw);
    chk("R4 empty", empty_o, (pi == ci && pw == cw));
    chk("R5 full", full_o, (pi == ci && pw != cw));
    chk("R6 inconsistent", inconsistent_o,
        ((pi > ci && pw != cw) || (pi < ci && pw == cw)));
    chk("R7 prod addr", prod_addr_o, (ba + EBYTES * pi) % 64'h1_0000_0000);
    chk("R7 cons addr", cons_addr_o, (ba + EBYTES * ci) % 64'h1_0000_0000);
  endtask

  // One cycle: strobes are driven now, captured at the next posedge,
  // and the model and checks are applied at the following negedge.
  task automatic cycle(input bit pinc, input bit cinc, input bit pwr, input int unsigned pd,
                       input bit cwr, input int unsigned cd, input string ptag);
    prod_inc_i = pinc; cons_inc_i = cinc;
    prod_wr_i = pwr; prod_wr_data_i = PTR_W'(pd);
    cons_wr_i = cwr; cons_wr_data_i = PTR_W'(cd);
    @(negedge clk);
    if (pwr) mp = pd % 256; else if (pinc) mp = bump(mp, eff_l(mbase));
    if (cwr) mc = cd % 256; else if (cinc) mc = bump(mc, eff_l(mbase));
    prod_inc_i = 0; cons_inc_i = 0; prod_wr_i = 0; cons_wr_i = 0;
    check_all(ptag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual timeout expected run completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int fields[8] = '{0, 1, 2, 3, 4, 5, 9, 31};
    // R1: reset state with a base whose low bits are nonzero
    base_i = 32'h8000_0123; mbase = base_i;
    repeat (3) @(negedge clk);
    mp = 0; mc = 0;
    check_all("R1");
    rst = 0;
    cycle(0, 0, 0, 0, 0, 0, "R10");

    // R2/R4/R5/R6/R7: every index/lap pair at each size, junk upper bits
    foreach (fields[k]) begin
      int unsigned l = (fields[k] > MAXL) ? MAXL : fields[k];
      int unsigned n = 2 << l;
      base_i = 32'h1234_5600 + 32'(k << 5) + 32'(fields[k]);
      mbase = base_i;
      for (int unsigned p = 0; p < n; p++) begin
        for (int unsigned c = 0; c < n; c++) begin
          cycle(0, 0, 1, (p + ((p * 37 + c) << (l + 1))) % 256,
                1, (c + ((c * 11 + p + 3) << (l + 1))) % 256, "R8");
        end
      end
      // R3/R9: step through more than a double lap, consumer every other cycle
      cycle(0, 0, 1, 8'hC0 | (l + 1) % (1 << l), 1, 8'h40, "R8");
      for (int i = 0; i < int'(n) + 3; i++) begin
        cycle(1, i % 2 == 1, 0, 0, 0, 0, (i % 2 == 1) ? "R9" : "R3");
      end
    end

    // R8: write wins over increment on both sides
    base_i = 32'hFFFF_FFE3; mbase = base_i;
    cycle(0, 0, 1, 8'h07, 1, 8'h0F, "R8");
    cycle(1, 1, 1, 8'hA5, 1, 8'h5A, "R8");
    // R7: address arithmetic wraps at the top of the address space
    cycle(0, 0, 1, 8'h07, 1, 8'h03, "R7");
    // R10: no strobes, pointers hold
    cycle(0, 0, 0, 0, 0, 0, "R10");
    // R10: size change alone is reflected after one edge
    base_i = 32'h0000_1002; mbase = base_i;
    cycle(0, 0, 0, 0, 0, 0, "R10");
    // R3: with L=0 each increment toggles bit 0 only
    base_i = 32'h0000_2000; mbase = base_i;
    cycle(0, 0, 1, 8'hF0, 1, 8'hF0, "R8");
    cycle(1, 0, 0, 0, 0, 0, "R3");
    cycle(1, 1, 0, 0, 0, 0, "R3");
    // R1: reset again mid-run
    rst = 1;
    @(negedge clk);
    mp = 0; mc = 0;
    check_all("R1");
    rst = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule